// File: doc/BRIEF.md
# Serial Display-Word Receiver

This block takes display updates from a host over three wires: a data line, a data clock and a write strobe. All three are sampled by the system clock, and the block acts on their rising edges. Each rising data-clock edge shifts one bit into a ten-bit word. The word holds a four-bit digit address and a six-bit segment code. The code is made of two annunciator bits and four character bits.

A rising write strobe ends the word. If exactly ten bits arrived since the previous write, and the address names one of the ten digits, the block does three things. It presents the code, pulses a one-hot enable for the addressed digit's output latch, and raises its data-accepted output. Any other write is refused: data-accepted goes low and no latch is touched.

The host must issue one write after reset before it sends a word. That first write arms the input logic. Data clocks that arrive before it are ignored.

Top module: `disp_ser_rx`

## Requirements
- R1: While reset is active, and after it ends, `data_acc_o` is 0, `dig_en_o` is all zero and `code_o` is zero.
- R2: Each data-clock rising edge shifts `ser_data_i` into the low end of the word, and the older bits move one place toward the high end. After ten clocks, the first four bits sent (most significant first) form the digit address. The last six bits (most significant first) form the code. Code bits 5:4 are the annunciators and bits 3:0 are the character.
- R3: A write is accepted when it comes after exactly ten data clocks with an address of 0 to 9. One clock after the write edge is sampled, `dig_en_o` has only bit [address] set, `code_o` equals the shifted code and `data_acc_o` is 1.
- R4: A write with address 10 to 15 is refused. `data_acc_o` goes to 0, `dig_en_o` stays zero and `code_o` keeps its previous value.
- R5: A write after any data-clock count other than ten (fewer or more) is refused. `data_acc_o` goes to 0, `dig_en_o` stays zero and `code_o` keeps its previous value.
- R6: `data_acc_o` holds its level from one write until the next, whatever happens on the data clock in between.
- R7: Every write, whether accepted or refused, restarts the bit count at zero. Ten more clocks then make a complete word.
- R8: After reset, data clocks are ignored until the first write. That first write is refused, because its count is zero.
- R9: `dig_en_o` has at most one bit set, and that bit lasts exactly one clock cycle per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data_i | input | 1 | Serial data bit |
| ser_clk_i | input | 1 | Serial data clock; acts on its rising edge |
| ser_wr_i | input | 1 | Write strobe; acts on its rising edge |
| data_acc_o | output | 1 | High after an accepted write, low after a refused one |
| dig_en_o | output | 10 | One-hot load enable for the per-digit latches |
| code_o | output | 6 | Segment code of the last accepted word |

## Verification
An input edge is seen at the first system clock edge where the level is high, and the state is registered at that same edge. So a shifted bit is in the word one cycle after it is driven. The write results (enable, code, data-accepted) appear at the output registers that same cycle.

The bench drives each level just after a falling edge and samples outputs at the next falling edge, which is the only cycle in which the enable pulse can be seen. It samples once more one cycle later to confirm the pulse has cleared and data-accepted has held.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;

    typedef enum logic [1:0] {
        VERDICT_NONE     = 2'd0,
        VERDICT_TAKE     = 2'd1,
        VERDICT_BAD_ADDR = 2'd2,
        VERDICT_BAD_LEN  = 2'd3
    } verdict_e;

endpackage

// File: rtl/disp_ser_edge.sv
module disp_ser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise_o    = level_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/disp_ser_shifter.sv
module disp_ser_shifter #(
    parameter int WORD_BITS = 10
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bit_i,
    input  logic                                 shift_i,
    input  logic                                 wr_i,
    output logic [WORD_BITS-1:0]                 word_o,
    output logic [$clog2(WORD_BITS+2)-1:0]       cnt_o,
    output logic                                 armed_o
);

    localparam int CNT_W = $clog2(WORD_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_BITS + 1);

    typedef struct packed {
        logic [WORD_BITS-1:0] word;
        logic [CNT_W-1:0]     cnt;
        logic                 armed;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (shift_i && st_q.armed) begin
            st_d.word = {st_q.word[WORD_BITS-2:0], bit_i};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign cnt_o   = st_q.cnt;
    assign armed_o = st_q.armed;

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SAT);

    assert_unarmed_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> st_q.cnt == '0);

    assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> cnt_o == '0);

endmodule

// File: rtl/disp_ser_decode.sv
module disp_ser_decode
    import disp_ser_pkg::*;
#(
    parameter int NUM_DIGITS = 10,
    parameter int ADDR_W     = 4,
    parameter int CODE_W     = 6
) (
    input  logic [ADDR_W+CODE_W-1:0]             word_i,
    input  logic [$clog2(ADDR_W+CODE_W+2)-1:0]   cnt_i,
    input  logic                                 wr_i,
    output verdict_e                             verdict_o,
    output logic [NUM_DIGITS-1:0]                sel_o,
    output logic [CODE_W-1:0]                    code_o
);

    localparam int WORD_BITS = ADDR_W + CODE_W;
    localparam int CNT_W     = $clog2(WORD_BITS + 2);

    logic [ADDR_W-1:0] addr;
    logic              len_ok;
    logic              addr_ok;

    assign addr    = word_i[WORD_BITS-1:CODE_W];
    assign code_o  = word_i[CODE_W-1:0];
    assign len_ok  = (cnt_i == CNT_W'(WORD_BITS));
    assign addr_ok = (32'(addr) < NUM_DIGITS);

    always_comb begin
        if (!wr_i)         verdict_o = VERDICT_NONE;
        else if (!len_ok)  verdict_o = VERDICT_BAD_LEN;
        else if (!addr_ok) verdict_o = VERDICT_BAD_ADDR;
        else               verdict_o = VERDICT_TAKE;
    end

    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_sel
        assign sel_o[gi] = (addr == ADDR_W'(gi));
    end

endmodule

// File: rtl/disp_ser_rx.sv
module disp_ser_rx
    import disp_ser_pkg::*;
#(
    parameter int NUM_DIGITS = 10,
    parameter int ADDR_W     = 4,
    parameter int CODE_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_data_i,
    input  logic                  ser_clk_i,
    input  logic                  ser_wr_i,
    output logic                  data_acc_o,
    output logic [NUM_DIGITS-1:0] dig_en_o,
    output logic [CODE_W-1:0]     code_o
);

    localparam int WORD_BITS = ADDR_W + CODE_W;
    localparam int CNT_W     = $clog2(WORD_BITS + 2);

    typedef struct packed {
        logic                  acc;
        logic [NUM_DIGITS-1:0] en;
        logic [CODE_W-1:0]     code;
    } out_st_t;

    out_st_t st_d, st_q;

    logic                  clk_rise;
    logic                  wr_rise;
    logic [WORD_BITS-1:0]  word;
    logic [CNT_W-1:0]      cnt;
    logic                  armed;
    verdict_e              verdict;
    logic [NUM_DIGITS-1:0] sel;
    logic [CODE_W-1:0]     new_code;

    disp_ser_edge u_clk_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (ser_clk_i),
        .rise_o  (clk_rise)
    );

    disp_ser_edge u_wr_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (ser_wr_i),
        .rise_o  (wr_rise)
    );

    disp_ser_shifter #(
        .WORD_BITS (WORD_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (ser_data_i),
        .shift_i (clk_rise),
        .wr_i    (wr_rise),
        .word_o  (word),
        .cnt_o   (cnt),
        .armed_o (armed)
    );

    disp_ser_decode #(
        .NUM_DIGITS (NUM_DIGITS),
        .ADDR_W     (ADDR_W),
        .CODE_W     (CODE_W)
    ) u_dec (
        .word_i    (word),
        .cnt_i     (cnt),
        .wr_i      (wr_rise),
        .verdict_o (verdict),
        .sel_o     (sel),
        .code_o    (new_code)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = '0;
        case (verdict)
            VERDICT_TAKE: begin
                st_d.acc  = 1'b1;
                st_d.en   = sel;
                st_d.code = new_code;
            end
            VERDICT_BAD_ADDR,
            VERDICT_BAD_LEN: st_d.acc = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_acc_o = st_q.acc;
    assign dig_en_o   = st_q.en;
    assign code_o     = st_q.code;

    assert_enable_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en_o));

    assert_enable_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en_o != '0) |=> (dig_en_o == '0));

    assert_enable_needs_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en_o != '0) |-> data_acc_o);

    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rise |=> $stable(data_acc_o));

    assert_reject_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && cnt != CNT_W'(WORD_BITS)) |=> (dig_en_o == '0 && !data_acc_o && $stable(code_o)));

    assert_first_write_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && !armed) |=> !data_acc_o);

endmodule

// File: tb/disp_ser_rx_test.sv
`timescale 1ns/1ps
module disp_ser_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data_i = 1'b0;
    logic       ser_clk_i = 1'b0;
    logic       ser_wr_i = 1'b0;
    logic       data_acc_o;
    logic [9:0] dig_en_o;
    logic [5:0] code_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       s_acc;
    logic [9:0] s_en;
    logic [5:0] s_code;

    always #10 clk = ~clk;

    disp_ser_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_data_i (ser_data_i),
        .ser_clk_i  (ser_clk_i),
        .ser_wr_i   (ser_wr_i),
        .data_acc_o (data_acc_o),
        .dig_en_o   (dig_en_o),
        .code_o     (code_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data_i = b;
        ser_clk_i  = 1'b1;
        @(negedge clk);
        ser_clk_i  = 1'b0;
    endtask

    task automatic send_bits(input logic [9:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic send_word(input logic [3:0] addr, input logic [5:0] code);
        send_bits({addr, code}, 10);
    endtask

    // Drive a write edge; capture outputs one cycle later, then confirm the enable clears.
    task automatic pulse_write(input string tag);
        @(negedge clk);
        ser_wr_i = 1'b1;
        @(negedge clk);
        s_acc  = data_acc_o;
        s_en   = dig_en_o;
        s_code = code_o;
        ser_wr_i = 1'b0;
        @(negedge clk);
        check({tag, " R9 enable cleared"}, 32'(dig_en_o), 32'h0);
        check({tag, " R6 acc held"}, 32'(data_acc_o), 32'(s_acc));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 acc", 32'(data_acc_o), 32'h0);
        check("R1 enable", 32'(dig_en_o), 32'h0);
        check("R1 code", 32'(code_o), 32'h0);
    endtask

    task automatic t_preinit();
        send_word(4'd3, 6'h15);
        pulse_write("R8 first");
        check("R8 first write acc", 32'(s_acc), 32'h0);
        check("R8 first write enable", 32'(s_en), 32'h0);
        check("R8 first write code", 32'(s_code), 32'h0);
    endtask

    task automatic t_valid(input logic [3:0] addr, input logic [5:0] code);
        send_word(addr, code);
        pulse_write("R3 valid");
        check("R3 acc", 32'(s_acc), 32'h1);
        check("R3 R9 enable onehot", 32'(s_en), 32'(10'b1 << addr));
        check("R2 R3 code", 32'(s_code), 32'(code));
    endtask

    task automatic t_bad_addr(input logic [3:0] addr, input logic [5:0] prev);
        send_word(addr, 6'h2D);
        pulse_write("R4 bad addr");
        check("R4 acc", 32'(s_acc), 32'h0);
        check("R4 enable", 32'(s_en), 32'h0);
        check("R4 code kept", 32'(s_code), 32'(prev));
    endtask

    task automatic t_bad_len(input int n, input logic [5:0] prev);
        send_bits(10'b0010_110011, n);
        if (n > 10) send_bits(10'h0, n - 10);
        pulse_write("R5 bad length");
        check("R5 acc", 32'(s_acc), 32'h0);
        check("R5 enable", 32'(s_en), 32'h0);
        check("R5 code kept", 32'(s_code), 32'(prev));
    endtask

    task automatic t_hold(input logic exp_acc);
        send_bits(10'h2A5, 5);
        repeat (20) @(negedge clk);
        check("R6 acc level between writes", 32'(data_acc_o), 32'(exp_acc));
        check("R6 enable idle", 32'(dig_en_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 acc in reset", 32'(data_acc_o), 32'h0);
        rst_n = 1'b1;
        t_reset();
        t_preinit();
        t_valid(4'd0, 6'h2A);
        t_valid(4'd9, 6'h3F);
        t_valid(4'd5, 6'h01);
        t_hold(1'b1);
        pulse_write("R7 flush");
        t_bad_addr(4'd10, 6'h01);
        t_bad_addr(4'd15, 6'h01);
        t_hold(1'b0);
        pulse_write("R7 flush2");
        t_bad_len(9, 6'h01);
        t_valid(4'd7, 6'h1C);
        t_bad_len(11, 6'h1C);
        t_valid(4'd2, 6'h33);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule